// File: doc/BRIEF.md
# Outbound Address Window Register Set

This block holds the translation windows of a local-bus-to-PCIe bridge: one configuration-space window, one message window, a parameterised number of outbound memory windows (three by default) and one register window. Each window has a 64-bit base and a 64-bit mask. Software writes them as 32-bit halves over a DCR-style register port. The port answers at one of two block base addresses, chosen by a strap input.

The block derives each window's size from its mask. It compares every lookup address against all enabled windows and, one cycle later, reports which window won as a one-hot vector. It also reports the offset of the address from that window's base and the size of the window. The bridge datapath uses these outputs to steer outbound requests.

Top module: `oaw_window_set`

## Requirements
- R1: After a synchronous active-low reset, every base half and every mask low half reads 0, so every window is disabled and any lookup misses.
- R2: With `inst_sel`=0 the registers occupy DCR addresses 0x100..0x117, and with `inst_sel`=1 they occupy 0x120..0x137. Within the block, window w sits at offset 4*w with fields base-high (+0), base-low (+1), mask-high (+2) and mask-low (+3). The window order is 0 configuration, 1 message, 2..4 memory, 5 register. `dcr_ack` is high only for a read or write inside the active range. A read outside the range returns 0.
- R3: A write to one half of a base or mask changes only that half; the other half keeps its value.
- R4: The mask-high field of the configuration, message and register windows always reads 0xFFFFFFFF and ignores writes. The memory windows' mask-high fields are writable and reset to 0.
- R5: Bit 0 of a window's mask-low field enables it. A window with this bit clear never hits.
- R6: A window's size is the inverse of its mask with bit 0 cleared, plus one, taken modulo 2^64; a size of 0 means the full 2^64 space. An address hits when (address XOR base) AND NOT(size-1) is zero.
- R7: When the register window's mask-low field equals 0x7001, its size is 4096 and it matches one 4 KiB-aligned page. The same value in any other window follows R6.
- R8: When several enabled windows match, the lowest-numbered window wins, and `hit_onehot` never has more than one bit set.
- R9: A lookup presented with `look_vld` produces `hit_vld`=1 on the following cycle. Alongside it, `hit_offset` is the address minus the winner's base and `hit_size` is the winner's size. On a miss, or when no lookup was requested, the one-hot vector, the offset and the size are all 0, and `hit_vld` is 0 when no lookup was requested.
- R10: A lookup in the same cycle as a register write is decoded against the register contents from before that write.
- R11: `dcr_rdata` presents the addressed field in the same cycle that `dcr_rd` is high, and is 0 whenever `dcr_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inst_sel | input | 1 | Strap selecting the block base address (0: 0x100, 1: 0x120) |
| dcr_addr | input | 10 | Register port address |
| dcr_rd | input | 1 | Register read strobe |
| dcr_wr | input | 1 | Register write strobe |
| dcr_wdata | input | 32 | Register write data |
| dcr_rdata | output | 32 | Register read data, combinational |
| dcr_ack | output | 1 | Access falls inside this block |
| look_vld | input | 1 | Lookup request |
| look_addr | input | 64 | Address to decode |
| hit_vld | output | 1 | Lookup result valid |
| hit_onehot | output | 6 | Winning window, one-hot |
| hit_offset | output | 64 | Address minus winning base |
| hit_size | output | 64 | Size of winning window |

## Verification
The two functions that can meet in one cycle are a register write and an address lookup. The bench provokes this by raising `dcr_wr`, which clears the enable of the window covering the address, at the same clock edge as `look_vld`. The lookup result must still show that window as the hit, because the decode sees the old contents. A second lookup, issued right after, must miss. Sweeps of mask sizes per window, overlapping windows and the special register-window mask are all judged against a bench model built from the requirements.

// File: rtl/oaw_pkg.sv
// Shared types for the outbound address window register set.
// Assumes a 32-bit register port and 64-bit local addresses.
package oaw_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 64;

    typedef logic [ADDR_W-1:0] addr_t;

    // Field position inside one window's four-word group (the order is decoded).
    typedef enum logic [1:0] {
        FLD_BASE_HI = 2'd0,
        FLD_BASE_LO = 2'd1,
        FLD_MASK_HI = 2'd2,
        FLD_MASK_LO = 2'd3
    } field_e;
endpackage

// File: rtl/oaw_regfile.sv
// Register storage and register-port decode for all windows.
// Assumes windows 0,1 and the last are fixed-high-mask windows and the
// ones in between are memory windows with writable mask-high halves.
module oaw_regfile
    import oaw_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int DCR_AW  = 10,
    parameter int BASE_A  = 'h100,
    parameter int BASE_B  = 'h120
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inst_sel,
    input  logic [DCR_AW-1:0]        dcr_addr,
    input  logic                     dcr_rd,
    input  logic                     dcr_wr,
    input  logic [REG_W-1:0]         dcr_wdata,
    output logic [REG_W-1:0]         dcr_rdata,
    output logic                     dcr_ack,
    output addr_t [NUM_WIN-1:0]      base_o,
    output addr_t [NUM_WIN-1:0]      mask_o,
    output logic  [NUM_WIN-1:0]      en_o
);
    localparam int IDX_W = DCR_AW - 2;
    localparam logic [DCR_AW-1:0] BA   = DCR_AW'(BASE_A);
    localparam logic [DCR_AW-1:0] BB   = DCR_AW'(BASE_B);
    localparam logic [DCR_AW-1:0] SPAN = DCR_AW'(NUM_WIN * 4);

    logic [DCR_AW-1:0] blk_base;
    logic [DCR_AW-1:0] offs;
    logic              in_rng;
    logic              wr_go;
    logic [IDX_W-1:0]  win_idx;
    field_e            fld;

    // Locate the access relative to the strapped block base.
    assign blk_base = inst_sel ? BB : BA;
    assign offs     = dcr_addr - blk_base;
    assign in_rng   = offs < SPAN;
    assign win_idx  = offs[DCR_AW-1:2];
    assign fld      = field_e'(offs[1:0]);
    assign wr_go    = dcr_wr && in_rng;
    assign dcr_ack  = (dcr_rd || dcr_wr) && in_rng;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [REG_W-1:0] bhi, blo, mhi, mlo;
        logic             sel;

        assign sel = wr_go && (win_idx == IDX_W'(w));

        // Base halves and mask-low half: each half written on its own.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bhi <= '0;
                blo <= '0;
                mlo <= '0;
            end else if (sel) begin
                case (fld)
                    FLD_BASE_HI: bhi <= dcr_wdata;
                    FLD_BASE_LO: blo <= dcr_wdata;
                    FLD_MASK_LO: mlo <= dcr_wdata;
                    default:     ;
                endcase
            end
        end

        if (w >= 2 && w < NUM_WIN - 1) begin : g_mem
            // Memory window: mask-high half is a real register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mhi <= '0;
                else if (sel && fld == FLD_MASK_HI)
                    mhi <= dcr_wdata;
            end
        end else begin : g_fixed
            // 32-bit-mask window: upper mask bits tied to ones.
            assign mhi = '1;
        end

        assign base_o[w] = {bhi, blo};
        assign mask_o[w] = {mhi, mlo};
        assign en_o[w]   = mlo[0];
    end

    // Read multiplexer: zero unless an in-range read is under way.
    always_comb begin
        dcr_rdata = '0;
        if (dcr_rd && in_rng) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (win_idx == IDX_W'(w)) begin
                    case (fld)
                        FLD_BASE_HI: dcr_rdata = base_o[w][ADDR_W-1:REG_W];
                        FLD_BASE_LO: dcr_rdata = base_o[w][REG_W-1:0];
                        FLD_MASK_HI: dcr_rdata = mask_o[w][ADDR_W-1:REG_W];
                        default:     dcr_rdata = mask_o[w][REG_W-1:0];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/oaw_match.sv
// Size derivation and address compare for one window.
// Assumes the special mask value has bit 0 set, so it also enables.
module oaw_match
    import oaw_pkg::*;
#(
    parameter bit          IS_REG       = 1'b0,
    parameter logic [31:0] SPECIAL_MASK = 32'h0000_7001,
    parameter logic [63:0] SPECIAL_SIZE = 64'd4096
) (
    input  addr_t base_i,
    input  addr_t mask_i,
    input  logic  en_i,
    input  addr_t look_addr_i,
    output logic  hit_o,
    output addr_t size_o
);
    addr_t plain_size;
    addr_t dmask;
    logic  special;

    // Two's complement of the mask with its enable bit cleared.
    assign plain_size = ~(mask_i & ~ADDR_W'(1)) + ADDR_W'(1);

    if (IS_REG) begin : g_special
        assign special = (mask_i[31:0] == SPECIAL_MASK);
    end else begin : g_plain
        assign special = 1'b0;
    end

    // Size picks the override when it applies; compare mask follows the size.
    assign size_o = special ? SPECIAL_SIZE : plain_size;
    assign dmask  = ~(size_o - ADDR_W'(1));
    assign hit_o  = en_i && (((look_addr_i ^ base_i) & dmask) == '0);
endmodule

// File: rtl/oaw_select.sv
// Priority pick among window hits and the registered lookup result.
// Assumes lower window index means higher priority.
module oaw_select
    import oaw_pkg::*;
#(
    parameter int NUM_WIN = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 look_vld,
    input  addr_t                look_addr,
    input  logic  [NUM_WIN-1:0]  hit_vec,
    input  addr_t [NUM_WIN-1:0]  size_vec,
    input  addr_t [NUM_WIN-1:0]  base_vec,
    output logic                 hit_vld,
    output logic  [NUM_WIN-1:0]  hit_onehot,
    output addr_t                hit_offset,
    output addr_t                hit_size
);
    logic [NUM_WIN-1:0] win;
    addr_t              nxt_off;
    addr_t              nxt_size;

    // Keep only the lowest set bit of the hit vector.
    assign win = hit_vec & (~hit_vec + NUM_WIN'(1));

    // Gather offset and size of the winning window.
    always_comb begin
        nxt_off  = '0;
        nxt_size = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win[w]) begin
                nxt_off  = look_addr - base_vec[w];
                nxt_size = size_vec[w];
            end
        end
    end

    // Register the result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n || !look_vld) begin
            hit_vld    <= 1'b0;
            hit_onehot <= '0;
            hit_offset <= '0;
            hit_size   <= '0;
        end else begin
            hit_vld    <= 1'b1;
            hit_onehot <= win;
            hit_offset <= nxt_off;
            hit_size   <= nxt_size;
        end
    end
endmodule

// File: rtl/oaw_window_set.sv
// Top of the outbound address window register set: register port,
// per-window size/compare, priority select.
// Assumes the two block bases are at least NUM_WIN*4 words apart.
module oaw_window_set
    import oaw_pkg::*;
#(
    parameter int          NUM_MEM      = 3,
    parameter int          DCR_AW       = 10,
    parameter int          BASE_A       = 'h100,
    parameter int          BASE_B       = 'h120,
    parameter logic [31:0] SPECIAL_MASK = 32'h0000_7001,
    parameter logic [63:0] SPECIAL_SIZE = 64'd4096,
    localparam int         NUM_WIN      = NUM_MEM + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inst_sel,
    input  logic [DCR_AW-1:0]   dcr_addr,
    input  logic                dcr_rd,
    input  logic                dcr_wr,
    input  logic [31:0]         dcr_wdata,
    output logic [31:0]         dcr_rdata,
    output logic                dcr_ack,
    input  logic                look_vld,
    input  logic [63:0]         look_addr,
    output logic                hit_vld,
    output logic [NUM_WIN-1:0]  hit_onehot,
    output logic [63:0]         hit_offset,
    output logic [63:0]         hit_size
);
    addr_t [NUM_WIN-1:0] base_w;
    addr_t [NUM_WIN-1:0] mask_w;
    addr_t [NUM_WIN-1:0] size_w;
    logic  [NUM_WIN-1:0] en_w;
    logic  [NUM_WIN-1:0] hit_w;

    oaw_regfile #(
        .NUM_WIN (NUM_WIN),
        .DCR_AW  (DCR_AW),
        .BASE_A  (BASE_A),
        .BASE_B  (BASE_B)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .inst_sel  (inst_sel),
        .dcr_addr  (dcr_addr),
        .dcr_rd    (dcr_rd),
        .dcr_wr    (dcr_wr),
        .dcr_wdata (dcr_wdata),
        .dcr_rdata (dcr_rdata),
        .dcr_ack   (dcr_ack),
        .base_o    (base_w),
        .mask_o    (mask_w),
        .en_o      (en_w)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        oaw_match #(
            .IS_REG       (w == NUM_WIN - 1),
            .SPECIAL_MASK (SPECIAL_MASK),
            .SPECIAL_SIZE (SPECIAL_SIZE)
        ) u_match (
            .base_i      (base_w[w]),
            .mask_i      (mask_w[w]),
            .en_i        (en_w[w]),
            .look_addr_i (look_addr),
            .hit_o       (hit_w[w]),
            .size_o      (size_w[w])
        );
    end

    oaw_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_vld   (look_vld),
        .look_addr  (look_addr),
        .hit_vec    (hit_w),
        .size_vec   (size_w),
        .base_vec   (base_w),
        .hit_vld    (hit_vld),
        .hit_onehot (hit_onehot),
        .hit_offset (hit_offset),
        .hit_size   (hit_size)
    );
endmodule

// File: rtl/oaw_window_set_chk.sv
// Protocol checker for oaw_window_set, attached by bind.
// Assumes it sees the stored bases and window enables of the target.
module oaw_window_set_chk #(
    parameter int NUM_WIN = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dcr_rd,
    input logic                      dcr_wr,
    input logic                      dcr_ack,
    input logic                      look_vld,
    input logic                      hit_vld,
    input logic [NUM_WIN-1:0]        hit_onehot,
    input logic [63:0]               hit_offset,
    input logic [63:0]               hit_size,
    input logic [NUM_WIN-1:0][63:0]  base_q,
    input logic [NUM_WIN-1:0]        win_en
);
    a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_onehot));

    a_r9_valid_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        look_vld |=> hit_vld);

    a_r9_valid_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |-> $past(look_vld));

    a_r9_miss_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_onehot == '0) |-> (hit_offset == '0 && hit_size == '0));

    a_r2_ack_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        dcr_ack |-> (dcr_rd || dcr_wr));

    a_r11_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !dcr_rd && !dcr_wr |-> !dcr_ack);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
        a_r3_high_half_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(base_q[w][63:32]) |-> $past(dcr_wr));

        a_r3_low_half_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(base_q[w][31:0]) |-> $past(dcr_wr));

        a_r5_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            hit_onehot[w] |-> $past(win_en[w]));
    end
endmodule

bind oaw_window_set oaw_window_set_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dcr_rd     (dcr_rd),
    .dcr_wr     (dcr_wr),
    .dcr_ack    (dcr_ack),
    .look_vld   (look_vld),
    .hit_vld    (hit_vld),
    .hit_onehot (hit_onehot),
    .hit_offset (hit_offset),
    .hit_size   (hit_size),
    .base_q     (base_w),
    .win_en     (en_w)
);

// File: tb/oaw_window_set_tb_top.sv
`timescale 1ns/1ps
module oaw_window_set_tb_top;
    localparam int NW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inst_sel = 1'b0;
    logic [9:0]  dcr_addr = '0;
    logic        dcr_rd = 1'b0;
    logic        dcr_wr = 1'b0;
    logic [31:0] dcr_wdata = '0;
    logic [31:0] dcr_rdata;
    logic        dcr_ack;
    logic        look_vld = 1'b0;
    logic [63:0] look_addr = '0;
    logic        hit_vld;
    logic [NW-1:0] hit_onehot;
    logic [63:0] hit_offset;
    logic [63:0] hit_size;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [63:0] mb [NW];
    logic [63:0] mm [NW];

    always #2.5 clk = ~clk;

    oaw_window_set dut_i (
        .clk(clk), .rst_n(rst_n), .inst_sel(inst_sel),
        .dcr_addr(dcr_addr), .dcr_rd(dcr_rd), .dcr_wr(dcr_wr),
        .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .dcr_ack(dcr_ack),
        .look_vld(look_vld), .look_addr(look_addr), .hit_vld(hit_vld),
        .hit_onehot(hit_onehot), .hit_offset(hit_offset), .hit_size(hit_size)
    );

    function automatic bit is_mem(int w);
        return (w >= 2 && w < NW - 1);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] blk();
        return inst_sel ? 10'h120 : 10'h100;
    endfunction

    task automatic reg_wr(int w, int f, logic [31:0] v);
        @(negedge clk);
        dcr_addr  = blk() + 10'(4 * w + f);
        dcr_wdata = v;
        dcr_wr    = 1'b1;
        @(negedge clk);
        dcr_wr = 1'b0;
        case (f)
            0: mb[w][63:32] = v;
            1: mb[w][31:0]  = v;
            2: if (is_mem(w)) mm[w][63:32] = v;
            default: mm[w][31:0] = v;
        endcase
    endtask

    task automatic raw_rd(logic [9:0] a, output logic [31:0] d, output logic ack);
        @(negedge clk);
        dcr_addr = a;
        dcr_rd   = 1'b1;
        #1;
        d   = dcr_rdata;
        ack = dcr_ack;
        dcr_rd = 1'b0;
    endtask

    function automatic logic [31:0] model_rd(int w, int f);
        case (f)
            0: return mb[w][63:32];
            1: return mb[w][31:0];
            2: return mm[w][63:32];
            default: return mm[w][31:0];
        endcase
    endfunction

    task automatic check_reg(string tag, int w, int f);
        logic [31:0] d;
        logic ack;
        raw_rd(blk() + 10'(4 * w + f), d, ack);
        check({tag, " ack"}, 64'(ack), 64'd1);
        check({tag, " data"}, 64'(d), 64'(model_rd(w, f)));
    endtask

    task automatic set_win(int w, logic [63:0] b, logic [63:0] m);
        reg_wr(w, 0, b[63:32]);
        reg_wr(w, 1, b[31:0]);
        reg_wr(w, 2, m[63:32]);
        reg_wr(w, 3, m[31:0]);
    endtask

    task automatic disable_all();
        for (int j = 0; j < NW; j++) reg_wr(j, 3, 32'h0);
    endtask

    task automatic model_lookup(logic [63:0] a, output logic [NW-1:0] oh,
                                output logic [63:0] off, output logic [63:0] sz);
        oh = '0; off = '0; sz = '0;
        for (int w = 0; w < NW; w++) begin
            logic [63:0] s;
            if (w == NW - 1 && mm[w][31:0] == 32'h7001) s = 64'd4096;
            else s = ~(mm[w] & ~64'd1) + 64'd1;
            if (oh == '0 && mm[w][0] && (((a ^ mb[w]) & ~(s - 64'd1)) == 64'd0)) begin
                oh  = NW'(1) << w;
                off = a - mb[w];
                sz  = s;
            end
        end
    endtask

    task automatic lookup_check(string tag, logic [63:0] a);
        logic [NW-1:0] oh;
        logic [63:0] off, sz;
        model_lookup(a, oh, off, sz);
        @(negedge clk);
        look_vld = 1'b1;
        look_addr = a;
        @(negedge clk);
        look_vld = 1'b0;
        check({tag, " vld"}, 64'(hit_vld), 64'd1);
        check({tag, " onehot"}, 64'(hit_onehot), 64'(oh));
        check({tag, " offset"}, hit_offset, off);
        check({tag, " size"}, hit_size, sz);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic ack;
        for (int w = 0; w < NW; w++) begin
            mb[w] = '0;
            mm[w] = is_mem(w) ? 64'h0 : 64'hFFFF_FFFF_0000_0000;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4: reset contents of every field
        for (int w = 0; w < NW; w++)
            for (int f = 0; f < 4; f++) check_reg("R1 reset read", w, f);
        lookup_check("R1 reset lookup miss", 64'h0);
        lookup_check("R1 reset lookup miss high", 64'hFFFF_FFFF_FFFF_F000);

        // R9: no request, no result
        @(negedge clk);
        check("R9 idle vld", 64'(hit_vld), 64'd0);
        check("R9 idle onehot", 64'(hit_onehot), 64'd0);

        // R11: read data zero without a read
        dcr_addr = 10'h100;
        #1;
        check("R11 rdata idle", 64'(dcr_rdata), 64'd0);
        check("R11 ack idle", 64'(dcr_ack), 64'd0);

        // R2: address decode with inst_sel=0
        reg_wr(0, 0, 32'hA5A5_0001);
        check_reg("R2 base0 hi at 0x100", 0, 0);
        raw_rd(10'h120, d, ack);
        check("R2 other block ack", 64'(ack), 64'd0);
        check("R2 other block data", 64'(d), 64'd0);
        raw_rd(10'h118, d, ack);
        check("R2 past end ack", 64'(ack), 64'd0);
        raw_rd(10'h0FF, d, ack);
        check("R2 below start ack", 64'(ack), 64'd0);

        // R3: halves written independently
        reg_wr(2, 0, 32'h1111_2222);
        reg_wr(2, 1, 32'h3333_4444);
        check_reg("R3 base hi", 2, 0);
        check_reg("R3 base lo", 2, 1);
        reg_wr(2, 1, 32'h5555_6666);
        check_reg("R3 hi kept after lo write", 2, 0);
        check_reg("R3 lo updated", 2, 1);
        reg_wr(2, 0, 32'h7777_8888);
        check_reg("R3 lo kept after hi write", 2, 1);
        reg_wr(3, 3, 32'hABCD_0000);
        reg_wr(3, 2, 32'h0000_1234);
        check_reg("R3 mask lo kept", 3, 3);

        // R4: fixed mask-high halves ignore writes; memory ones take them
        reg_wr(0, 2, 32'h0);
        reg_wr(1, 2, 32'h1234_5678);
        reg_wr(5, 2, 32'h0);
        check_reg("R4 cfg mask hi fixed", 0, 2);
        check_reg("R4 msg mask hi fixed", 1, 2);
        check_reg("R4 reg mask hi fixed", 5, 2);
        check_reg("R4 mem mask hi writable", 3, 2);

        // R6: per-window size sweep
        for (int w = 0; w < NW; w++) begin
            disable_all();
            for (int k = 8; k <= 44; k += 4) begin
                logic [63:0] sz, b, m;
                if (!is_mem(w) && k > 28) continue;
                sz = 64'd1 << k;
                m  = ~(sz - 64'd1) | 64'd1;
                b  = 64'h1234_5678_9ABC_DEF0 & ~(sz - 64'd1);
                set_win(w, b, m);
                lookup_check("R6 base", b);
                lookup_check("R6 last byte", b + sz - 64'd1);
                lookup_check("R6 mid", b + (sz >> 1) + 64'd3);
                lookup_check("R6 just above", b + sz);
                lookup_check("R6 just below", b - 64'd1);
            end
        end

        // R6: full-space window (mask 1 on a memory window)
        disable_all();
        set_win(4, 64'h0000_0000_0000_1000, 64'h1);
        lookup_check("R6 full space", 64'hDEAD_BEEF_0000_0000);
        lookup_check("R6 full space low", 64'h0);

        // R5: clearing the enable stops hits
        disable_all();
        set_win(3, 64'h0000_0040_0000_0000, 64'hFFFF_FFFF_FFF0_0001);
        lookup_check("R5 enabled hit", 64'h0000_0040_0000_0100);
        reg_wr(3, 3, 32'hFFF0_0000);
        lookup_check("R5 disabled miss", 64'h0000_0040_0000_0100);

        // R7: special register-window mask
        disable_all();
        set_win(5, 64'h0000_0000_8000_5000, 64'hFFFF_FFFF_0000_7001);
        lookup_check("R7 special first", 64'h0000_0000_8000_5000);
        lookup_check("R7 special last", 64'h0000_0000_8000_5FFF);
        lookup_check("R7 special above", 64'h0000_0000_8000_6000);
        lookup_check("R7 special below", 64'h0000_0000_8000_4FFF);
        reg_wr(5, 3, 32'h0);
        set_win(0, 64'h0000_0000_8000_5000, 64'hFFFF_FFFF_0000_7001);
        lookup_check("R7 value on cfg window", 64'h0000_0000_8000_5000);
        lookup_check("R7 value on cfg window far", 64'h0000_0000_8001_5FFF);

        // R8: overlapping windows, lowest index wins
        disable_all();
        set_win(0, 64'h0000_0000_2000_0000, 64'hFFFF_FFFF_F000_0001);
        set_win(2, 64'h0000_0000_2000_0000, 64'hFFFF_FFFF_FF00_0001);
        set_win(5, 64'h0000_0000_2000_0000, 64'hFFFF_FFFF_FFF0_0001);
        lookup_check("R8 three overlap", 64'h0000_0000_2000_0010);
        reg_wr(0, 3, 32'h0);
        lookup_check("R8 two overlap", 64'h0000_0000_2000_0010);
        lookup_check("R8 only outer", 64'h0000_0000_2080_0000);
        reg_wr(2, 3, 32'h0);
        lookup_check("R8 last remaining", 64'h0000_0000_2000_0010);

        // R10: write and lookup in the same cycle
        disable_all();
        set_win(2, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_0001);
        @(negedge clk);
        dcr_addr  = blk() + 10'(4 * 2 + 3);
        dcr_wdata = 32'h0;
        dcr_wr    = 1'b1;
        look_vld  = 1'b1;
        look_addr = 64'h0000_0001_0000_0020;
        @(negedge clk);
        dcr_wr = 1'b0;
        look_vld = 1'b0;
        check("R10 same-cycle vld", 64'(hit_vld), 64'd1);
        check("R10 same-cycle old hit", 64'(hit_onehot), 64'd4);
        check("R10 same-cycle offset", hit_offset, 64'h20);
        mm[2][31:0] = 32'h0;
        lookup_check("R10 after write miss", 64'h0000_0001_0000_0020);

        // R2: second block base
        inst_sel = 1'b1;
        reg_wr(1, 1, 32'hCAFE_0042);
        check_reg("R2 alt base msg lo", 1, 1);
        check_reg("R2 alt base cfg hi", 0, 0);
        raw_rd(10'h100, d, ack);
        check("R2 old base ack", 64'(ack), 64'd0);
        check("R2 old base data", 64'(d), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule